// File: doc/BRIEF.md
# Register Producer Rename Table

This block keeps, for every architectural register, the tag of the issue-station slot that will produce the register's next value, together with the register's last committed value. Tag zero means that no producer is outstanding and the stored value is current. An issue slot uses the table to read its two source operands. Each source comes back either as a ready value with a zero tag, or as a nonzero producer tag that the consumer must wait for.

In the same cycle as the lookup, the issuing instruction can claim its destination register. The table then records the new station tag as that register's producer, and this replaces any earlier producer. The table also watches the result broadcast bus, which carries a tag and a data word. A register accepts the broadcast only while its recorded producer equals the broadcast tag. On a match the register stores the data and clears its producer tag. An older writer whose rename has been replaced can therefore never overwrite the younger one's claim. A source lookup that lands in the same cycle as the matching broadcast receives the broadcast data directly.

Top module: `rename_status_table`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears every register's producer tag to 0 and its value to 0.
- R2: A source lookup of a register whose producer tag is 0 returns the stored value and a tag of 0.
- R3: A source lookup of a register with a nonzero producer tag, and no matching broadcast in that cycle, returns that tag and a value of all zeros.
- R4: When iss_valid and iss_dst_en are both 1 at a rising edge, register iss_dst takes iss_tag as its producer from the next cycle. A later rename of the same register replaces the earlier tag.
- R5: A broadcast (bc_valid 1, bc_tag nonzero) whose tag equals a register's producer tag writes bc_data into that register and clears its tag to 0 at the same edge.
- R6: A broadcast whose tag differs from a register's producer tag, a broadcast with bc_tag 0, or bc_valid 0 leaves that register's tag and value unchanged.
- R7: When a rename and a matching broadcast reach the same register at the same edge, the new rename tag is kept and the broadcast data is still written into the value.
- R8: A source lookup whose register has a nonzero tag equal to a valid, nonzero bc_tag in the same cycle returns bc_data with a tag of 0.
- R9: Lookups return the state as it was before the current cycle's rename, so a source that equals the destination of the same issue sees the earlier producer or value.
- R10: With iss_valid 0 or iss_dst_en 0, no register's producer tag changes because of issue inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_dst_en | input | 1 | The issuing instruction writes a destination |
| iss_dst | input | 4 | Destination register index |
| iss_tag | input | 4 | Station tag of the issuing instruction (nonzero) |
| iss_src_a | input | 4 | First source register index |
| iss_src_b | input | 4 | Second source register index |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | 4 | Producer tag of the broadcast result |
| bc_data | input | 64 | Broadcast result data |
| src_a_tag | output | 4 | First source producer tag, 0 when ready |
| src_a_val | output | 64 | First source value, 0 when pending |
| src_b_tag | output | 4 | Second source producer tag, 0 when ready |
| src_b_val | output | 64 | Second source value, 0 when pending |

## Verification
Rename and broadcast can hit the same register in the same cycle. So can a source lookup and the broadcast that resolves that source's producer. Directed cycles set up a pending tag and then, in a single cycle, drive the matching broadcast together with a new rename of that register and with a lookup of it. The bench then judges the lookup outputs in that cycle and the surviving tag in the next. A long stretch of random issue and broadcast traffic follows, with broadcast tags taken from the currently pending producers. It is compared every cycle against a behavioural per-register model.

// File: rtl/rst_pkg.sv
package rst_pkg;

   // How a read port resolved its answer this cycle.
   typedef enum logic [1:0] {
      RD_TABLE   = 2'd0,
      RD_PENDING = 2'd1,
      RD_BYPASS  = 2'd2
   } rd_src_e;

endpackage

// File: rtl/rst_entry.sv
module rst_entry #(
   parameter int DATA_W = 64,
   parameter int TAG_W  = 4,
   parameter int IDX_W  = 4,
   parameter int IDX    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ren_valid,
   input  logic [IDX_W-1:0]  ren_idx,
   input  logic [TAG_W-1:0]  ren_tag,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_data,
   output logic [TAG_W-1:0]  tag_o,
   output logic [DATA_W-1:0] val_o
);

   logic [TAG_W-1:0]  tag_q;
   logic [DATA_W-1:0] val_q;
   logic              ren_hit;
   logic              bc_hit;

   assign ren_hit = ren_valid && (ren_idx == IDX_W'(IDX));
   assign bc_hit  = bc_valid && (bc_tag != '0) && (tag_q == bc_tag);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q <= '0;
         val_q <= '0;
      end else begin
         if (ren_hit)
            tag_q <= ren_tag;
         else if (bc_hit)
            tag_q <= '0;
         if (bc_hit)
            val_q <= bc_data;
      end
   end

   assign tag_o = tag_q;
   assign val_o = val_q;

   // R4: a rename lands on the next cycle
   a_r4_rename_lands: assert property (@(posedge clk) disable iff (!rst_n)
      ren_hit |=> (tag_q == $past(ren_tag)));

   // R5: a matching broadcast without rename clears the producer
   a_r5_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_hit && !ren_hit) |=> (tag_q == '0 && val_q == $past(bc_data)));

   // R6: the value moves only on a matching broadcast
   a_r6_value_held: assert property (@(posedge clk) disable iff (!rst_n)
      !bc_hit |=> $stable(val_q));

   // R7: rename wins the tag, data still written
   a_r7_rename_and_match: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_hit && bc_hit) |=> (tag_q == $past(ren_tag) && val_q == $past(bc_data)));

endmodule

// File: rtl/rst_read_port.sv
module rst_read_port
   import rst_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int TAG_W    = 4,
   parameter int NUM_REGS = 16,
   parameter int IDX_W    = 4,
   parameter bit BYPASS   = 1'b1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [IDX_W-1:0]                 sel,
   input  logic [NUM_REGS-1:0][TAG_W-1:0]   tag_tbl,
   input  logic [NUM_REGS-1:0][DATA_W-1:0]  val_tbl,
   input  logic                             bc_valid,
   input  logic [TAG_W-1:0]                 bc_tag,
   input  logic [DATA_W-1:0]                bc_data,
   output logic [TAG_W-1:0]                 tag_o,
   output logic [DATA_W-1:0]                val_o
);

   logic [TAG_W-1:0]  cur_tag;
   logic [DATA_W-1:0] cur_val;
   logic              fwd_hit;
   rd_src_e           src;

   assign cur_tag = tag_tbl[sel];
   assign cur_val = val_tbl[sel];

   generate
      if (BYPASS) begin : g_fwd
         assign fwd_hit = bc_valid && (bc_tag != '0) && (cur_tag == bc_tag);
      end else begin : g_nofwd
         assign fwd_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      if (cur_tag == '0)
         src = RD_TABLE;
      else if (fwd_hit)
         src = RD_BYPASS;
      else
         src = RD_PENDING;
   end

   always_comb begin
      unique case (src)
         RD_TABLE: begin
            tag_o = '0;
            val_o = cur_val;
         end
         RD_BYPASS: begin
            tag_o = '0;
            val_o = bc_data;
         end
         default: begin
            tag_o = cur_tag;
            val_o = '0;
         end
      endcase
   end

   // R3: a pending answer hides the value and names the table's producer
   a_r3_pending_hides_value: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_o != '0) |-> (val_o == '0 && tag_o == tag_tbl[sel]));

   // R2: a ready register returns its stored value
   a_r2_ready_value: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_tbl[sel] == '0) |-> (tag_o == '0 && val_o == val_tbl[sel]));

   generate
      if (BYPASS) begin : g_fwd_chk
         // R8: coinciding matching broadcast is forwarded
         a_r8_forward: assert property (@(posedge clk) disable iff (!rst_n)
            (bc_valid && bc_tag != '0 && tag_tbl[sel] == bc_tag)
               |-> (tag_o == '0 && val_o == bc_data));
      end
   endgenerate

endmodule

// File: rtl/rename_status_table.sv
module rename_status_table #(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 64,
   parameter int TAG_W    = 4,
   parameter bit BYPASS   = 1'b1,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   input  logic              iss_dst_en,
   input  logic [IDX_W-1:0]  iss_dst,
   input  logic [TAG_W-1:0]  iss_tag,
   input  logic [IDX_W-1:0]  iss_src_a,
   input  logic [IDX_W-1:0]  iss_src_b,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_data,
   output logic [TAG_W-1:0]  src_a_tag,
   output logic [DATA_W-1:0] src_a_val,
   output logic [TAG_W-1:0]  src_b_tag,
   output logic [DATA_W-1:0] src_b_val
);

   generate
      if (NUM_REGS < 2) begin : g_bad_regs
         $error("NUM_REGS must be at least 2");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("TAG_W must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
   endgenerate

   logic                            ren_valid;
   logic [NUM_REGS-1:0][TAG_W-1:0]  tag_tbl;
   logic [NUM_REGS-1:0][DATA_W-1:0] val_tbl;

   assign ren_valid = iss_valid && iss_dst_en;

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
         rst_entry #(
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W),
            .IDX_W  (IDX_W),
            .IDX    (i)
         ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .ren_valid (ren_valid),
            .ren_idx   (iss_dst),
            .ren_tag   (iss_tag),
            .bc_valid  (bc_valid),
            .bc_tag    (bc_tag),
            .bc_data   (bc_data),
            .tag_o     (tag_tbl[i]),
            .val_o     (val_tbl[i])
         );
      end
   endgenerate

   rst_read_port #(
      .DATA_W (DATA_W), .TAG_W (TAG_W), .NUM_REGS (NUM_REGS),
      .IDX_W  (IDX_W),  .BYPASS (BYPASS)
   ) u_port_a (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (iss_src_a),
      .tag_tbl  (tag_tbl),
      .val_tbl  (val_tbl),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_data  (bc_data),
      .tag_o    (src_a_tag),
      .val_o    (src_a_val)
   );

   rst_read_port #(
      .DATA_W (DATA_W), .TAG_W (TAG_W), .NUM_REGS (NUM_REGS),
      .IDX_W  (IDX_W),  .BYPASS (BYPASS)
   ) u_port_b (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (iss_src_b),
      .tag_tbl  (tag_tbl),
      .val_tbl  (val_tbl),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_data  (bc_data),
      .tag_o    (src_b_tag),
      .val_o    (src_b_val)
   );

   // R10: no issue, no tag change on the named destination
   a_r10_no_rename: assert property (@(posedge clk) disable iff (!rst_n)
      (!ren_valid && !bc_valid) |=> $stable(tag_tbl));

   // R9: the source read sees the pre-rename producer of the destination
   a_r9_old_view: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_valid && iss_src_a == iss_dst && !bc_valid) |-> (src_a_tag == tag_tbl[iss_dst]));

endmodule

// File: tb/rename_status_table_tb.sv
`timescale 1ns/1ps
module rename_status_table_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        iss_valid, iss_dst_en;
   logic [3:0]  iss_dst, iss_tag, iss_src_a, iss_src_b;
   logic        bc_valid;
   logic [3:0]  bc_tag;
   logic [63:0] bc_data;
   logic [3:0]  src_a_tag, src_b_tag;
   logic [63:0] src_a_val, src_b_val;

   integer checks = 0;
   integer errors = 0;

   logic [3:0]  m_tag [16];
   logic [63:0] m_val [16];

   always #10 clk = ~clk;

   rename_status_table u_dut (
      .clk (clk), .rst_n (rst_n),
      .iss_valid (iss_valid), .iss_dst_en (iss_dst_en), .iss_dst (iss_dst),
      .iss_tag (iss_tag), .iss_src_a (iss_src_a), .iss_src_b (iss_src_b),
      .bc_valid (bc_valid), .bc_tag (bc_tag), .bc_data (bc_data),
      .src_a_tag (src_a_tag), .src_a_val (src_a_val),
      .src_b_tag (src_b_tag), .src_b_val (src_b_val)
   );

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic expect_src(int r, output logic [3:0] et, output logic [63:0] ev,
                             output string req);
      if (m_tag[r] == 4'd0) begin
         et = 4'd0; ev = m_val[r]; req = "R2";
      end else if (bc_valid && bc_tag != 4'd0 && bc_tag == m_tag[r]) begin
         et = 4'd0; ev = bc_data; req = "R8";
      end else begin
         et = m_tag[r]; ev = '0; req = "R3";
      end
   endtask

   task automatic step(string lbl, bit iv, bit de, int d, int tg, int sa, int sb,
                       bit bv, int bt, logic [63:0] bd);
      logic [3:0]  et;
      logic [63:0] ev;
      string       rq;
      @(negedge clk);
      iss_valid = iv; iss_dst_en = de; iss_dst = 4'(d); iss_tag = 4'(tg);
      iss_src_a = 4'(sa); iss_src_b = 4'(sb);
      bc_valid = bv; bc_tag = 4'(bt); bc_data = bd;
      #2;
      expect_src(sa, et, ev, rq);
      chk({lbl, " ", rq}, "src_a_tag", 64'(src_a_tag), 64'(et));
      chk({lbl, " ", rq}, "src_a_val", src_a_val, ev);
      expect_src(sb, et, ev, rq);
      chk({lbl, " ", rq}, "src_b_tag", 64'(src_b_tag), 64'(et));
      chk({lbl, " ", rq}, "src_b_val", src_b_val, ev);
      @(posedge clk);
      for (int i = 0; i < 16; i++) begin
         logic hit;
         hit = bv && (bt != 0) && (m_tag[i] == 4'(bt));
         if (hit) m_val[i] = bd;
         if (iv && de && d == i) m_tag[i] = 4'(tg);
         else if (hit) m_tag[i] = 4'd0;
      end
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      iss_valid = 0; iss_dst_en = 0; iss_dst = 0; iss_tag = 0;
      iss_src_a = 0; iss_src_b = 0; bc_valid = 0; bc_tag = 0; bc_data = '0;
      for (int i = 0; i < 16; i++) begin
         m_tag[i] = 4'd0;
         m_val[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: every register clean after reset
      for (int r = 0; r < 16; r++)
         step("R1", 0, 0, 0, 0, r, 15 - r, 0, 0, '0);

      // R4 with R9: rename r3 to tag 5, same-cycle read of r3 sees old state
      step("R9", 1, 1, 3, 5, 3, 3, 0, 0, '0);
      step("R4", 0, 0, 0, 0, 3, 3, 0, 0, '0);
      // R4 supersede, then stale broadcast of tag 5 (R6)
      step("R4", 1, 1, 3, 7, 3, 0, 0, 0, '0);
      step("R6", 0, 0, 0, 0, 3, 3, 1, 5, 64'hAAAA_0000_BBBB_0001);
      step("R6", 0, 0, 0, 0, 3, 3, 0, 0, '0);
      // R8 forward, then R5 resolved value
      step("R8", 0, 0, 0, 0, 3, 1, 1, 7, 64'h0000_1234_5678_9ABC);
      step("R5", 0, 0, 0, 0, 3, 3, 0, 0, '0);
      // R10: issue without valid or without destination
      step("R10", 0, 1, 4, 9, 4, 4, 0, 0, '0);
      step("R10", 1, 0, 4, 9, 4, 4, 0, 0, '0);
      step("R10", 0, 0, 0, 0, 4, 4, 0, 0, '0);
      // R7: rename and matching broadcast on r6 in the same cycle
      step("R7", 1, 1, 6, 2, 0, 0, 0, 0, '0);
      step("R7", 1, 1, 6, 3, 6, 6, 1, 2, 64'h55);
      step("R7", 0, 0, 0, 0, 6, 6, 0, 0, '0);
      step("R5", 0, 0, 0, 0, 6, 6, 1, 3, 64'h66);
      step("R5", 0, 0, 0, 0, 6, 6, 0, 0, '0);
      // R6: zero-tag broadcast ignored
      step("R6", 0, 0, 0, 0, 6, 0, 1, 0, 64'hFFFF);
      step("R6", 0, 0, 0, 0, 6, 0, 0, 0, '0);

      // Random traffic against the model
      for (int n = 0; n < 3000; n++) begin
         int pr;
         int btg;
         pr  = int'($urandom_range(0, 15));
         btg = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 15)) : int'(m_tag[pr]);
         step("RND", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0),
              int'($urandom_range(0, 15)), int'($urandom_range(1, 15)),
              int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
              1'($urandom_range(0, 2) != 0), btg, {$urandom, $urandom});
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule